// File: doc/BRIEF.md
# Data-First SPI Burst Read Sequencer

This block is the SPI slave transaction engine for a converter register file. It decodes one-byte instructions and serves single-register reads. It also holds the upper-address pointer that normal reads use. In addition, it provides a data-first mode. While that mode is on, every chip-select frame opens with a read burst that needs no instruction. The burst covers a window of consecutive registers, and two configuration inputs set the window's full start address and its length. Once the window has been shifted out, the same frame carries on as an ordinary instruction stream. A host can therefore fetch fresh conversion data with no command overhead and still reach every other register.

The SPI pins are oversampled in the system clock domain through two-flop synchronizers. The bus runs in clock mode 3. SCLK idles high, SDO moves after each falling SCLK edge, and SDI is captured on each rising edge. Bytes travel MSB first. The register file is read through a plain address/data port, and `rd_data_i` is expected to follow `rd_addr_o` combinationally.

Top module: `dfb_spi_seq`

## Requirements
- R1: After reset, `sdo_o` is 0, `upper_addr_o` is 0 and data-first mode is off, so a status read returns 0x00.
- R2: Instruction 0xD1 turns data-first mode on and 0xD0 turns it off, with effect from the next frame. Instruction 0xD5 is followed by one status byte whose bit 1 is the mode state and whose other bits are 0.
- R3: In data-first mode, a frame whose CSB falls while SCLK is high starts with a burst. The burst sends registers in ascending order from `cfg_start_i`, one byte per register, MSB first. SDO changes after each falling SCLK edge, and SDI is ignored during the burst.
- R4: The burst length is `cfg_count_i`, which is 3 bits wide, and the value 0 means eight bytes.
- R5: The start address is a full 7-bit address that includes its upper part. Addresses past 0x7F wrap to 0x00.
- R6: A burst never changes `upper_addr_o`.
- R7: After the last burst byte, SDO stays 0, and the following bytes of the same frame are decoded as normal instructions, including 0xD0.
- R8: Raising CSB during a burst aborts it. The next qualifying frame restarts from `cfg_start_i` with the full count.
- R9: If SCLK is low when CSB falls, the frame skips the burst and starts directly with an instruction.
- R10: Instruction 0x10 followed by a byte loads `upper_addr_o` with bits [2:0] of that byte. An instruction of the form 0x80 | L (L from 0 to 15) is followed by one byte holding the register at address {upper_addr_o, L}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the SPI pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock, idles high |
| csb_i | input | 1 | SPI chip select, active low |
| sdi_i | input | 1 | SPI data from the master |
| sdo_o | output | 1 | SPI data to the master |
| cfg_start_i | input | 7 | Burst start address |
| cfg_count_i | input | 3 | Burst byte count, where 0 means eight |
| rd_addr_o | output | 7 | Register-file read address |
| rd_data_i | input | 8 | Register-file read data |
| upper_addr_o | output | 3 | Held upper-address pointer for normal reads |

## Verification
Most internal faults show up on SDO within the byte where they occur. A wrong read pointer, a byte count that is off by one, or a missed wrap gives a wrong or extra burst byte. The scoreboard catches that on the eighth rising SCLK edge of the affected byte. A burst that touches the upper-address pointer is seen on `upper_addr_o` at once and again in the next normal read. A mode flag that is stuck or flipped by mistake shows up in the next status byte. It also shows as a burst that is present or absent at the start of the next frame. An abort that fails to restart the pointer is exposed by the first byte of the frame that follows.

// File: rtl/dfb_pkg.sv
package dfb_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_DF_ON   = 8'hD1;
  localparam logic [BYTE_W-1:0] OP_DF_OFF  = 8'hD0;
  localparam logic [BYTE_W-1:0] OP_STATUS  = 8'hD5;
  localparam logic [BYTE_W-1:0] OP_SET_UPR = 8'h10;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_BURST,
    PH_INSTR,
    PH_UPPER,
    PH_OUT
  } phase_e;
endpackage

// File: rtl/dfb_sync.sv
module dfb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/dfb_shifter.sv
module dfb_shifter
  import dfb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csb_i,
  input  logic              csb_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdi_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              sdo_o
);
  localparam int BC_W = $clog2(BYTE_W);

  logic [BC_W-1:0]   bit_cnt_q;
  logic [BYTE_W-1:0] rx_sr_q;
  logic [BYTE_W-1:0] tx_sr_q;
  logic              sdo_q;

  assign byte_done_o = sclk_rise_i && !csb_i && (bit_cnt_q == BC_W'(BYTE_W - 1));
  assign rx_byte_o   = {rx_sr_q[BYTE_W-2:0], sdi_i};
  assign sdo_o       = sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_sr_q   <= '0;
    end else if (csb_i || csb_fall_i) begin
      bit_cnt_q <= '0;
    end else if (sclk_rise_i) begin
      bit_cnt_q <= bit_cnt_q + 1'b1;
      rx_sr_q   <= rx_byte_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q <= '0;
      sdo_q   <= 1'b0;
    end else if (csb_i || csb_fall_i) begin
      tx_sr_q <= '0;
      sdo_q   <= 1'b0;
    end else if (load_i) begin
      tx_sr_q <= load_byte_i;
    end else if (sclk_fall_i) begin
      sdo_q   <= tx_sr_q[BYTE_W-1];
      tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b0};
    end
  end

  assert_bitcnt_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csb_fall_i |=> (bit_cnt_q == '0));
  assert_sdo_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csb_i |=> !sdo_q);
endmodule

// File: rtl/dfb_ctrl.sv
module dfb_ctrl
  import dfb_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int UPPER_W = 3,
  parameter int CNT_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csb_i,
  input  logic               csb_fall_i,
  input  logic               sclk_lvl_i,
  input  logic               byte_done_i,
  input  logic [BYTE_W-1:0]  rx_byte_i,
  input  logic [ADDR_W-1:0]  cfg_start_i,
  input  logic [CNT_W-1:0]   cfg_count_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic [ADDR_W-1:0]  rd_addr_o,
  output logic               load_o,
  output logic [BYTE_W-1:0]  load_byte_o,
  output logic [UPPER_W-1:0] upper_o
);
  localparam int LOWER_W   = ADDR_W - UPPER_W;
  localparam int LEFT_W    = CNT_W + 1;
  localparam int MAX_BURST = 1 << CNT_W;

  phase_e             phase_q;
  logic [ADDR_W-1:0]  ptr_q;
  logic [LEFT_W-1:0]  left_q;
  logic [UPPER_W-1:0] upper_q;
  logic               df_en_q;
  logic               fetch_q;
  logic               is_read;
  logic               status_hit;

  assign is_read    = rx_byte_i[BYTE_W-1] && (rx_byte_i[BYTE_W-2:LOWER_W] == '0);
  assign status_hit = byte_done_i && (phase_q == PH_INSTR) && (rx_byte_i == OP_STATUS);

  assign rd_addr_o = ptr_q;
  assign upper_o   = upper_q;

  always_comb begin
    load_o      = fetch_q || status_hit;
    load_byte_o = rd_data_i;
    if (!fetch_q) begin
      load_byte_o    = '0;
      load_byte_o[1] = df_en_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      ptr_q   <= '0;
      left_q  <= '0;
      upper_q <= '0;
      df_en_q <= 1'b0;
      fetch_q <= 1'b0;
    end else if (csb_fall_i) begin
      fetch_q <= 1'b0;
      if (df_en_q && sclk_lvl_i) begin
        phase_q <= PH_BURST;
        ptr_q   <= cfg_start_i;
        left_q  <= (cfg_count_i == '0) ? LEFT_W'(MAX_BURST) : {1'b0, cfg_count_i};
        fetch_q <= 1'b1;
      end else begin
        phase_q <= PH_INSTR;
      end
    end else if (csb_i) begin
      phase_q <= PH_IDLE;
      fetch_q <= 1'b0;
    end else begin
      if (fetch_q) begin
        ptr_q   <= ptr_q + 1'b1;
        fetch_q <= 1'b0;
      end
      if (byte_done_i) begin
        unique case (phase_q)
          PH_BURST: begin
            left_q <= left_q - 1'b1;
            if (left_q == LEFT_W'(1)) phase_q <= PH_INSTR;
            else                      fetch_q <= 1'b1;
          end
          PH_INSTR: begin
            if (rx_byte_i == OP_DF_ON)         df_en_q <= 1'b1;
            else if (rx_byte_i == OP_DF_OFF)   df_en_q <= 1'b0;
            else if (rx_byte_i == OP_STATUS)   phase_q <= PH_OUT;
            else if (rx_byte_i == OP_SET_UPR)  phase_q <= PH_UPPER;
            else if (is_read) begin
              ptr_q   <= {upper_q, rx_byte_i[LOWER_W-1:0]};
              fetch_q <= 1'b1;
              phase_q <= PH_OUT;
            end
          end
          PH_UPPER: begin
            upper_q <= rx_byte_i[UPPER_W-1:0];
            phase_q <= PH_INSTR;
          end
          PH_OUT:  phase_q <= PH_INSTR;
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assert_left_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_BURST) |-> (left_q >= LEFT_W'(1) && left_q <= LEFT_W'(MAX_BURST)));
  assert_upper_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_BURST) |=> $stable(upper_q));
  assert_mode_change_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(df_en_q) |-> $past(byte_done_i));
  assert_abort_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csb_i && !csb_fall_i) |=> (phase_q == PH_IDLE));
  assert_no_burst_sclk_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csb_fall_i && !sclk_lvl_i) |=> (phase_q == PH_INSTR));
endmodule

// File: rtl/dfb_spi_seq.sv
module dfb_spi_seq
  import dfb_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int UPPER_W  = 3,
  parameter int CNT_W    = 3,
  parameter int SYNC_STG = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               csb_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  input  logic [ADDR_W-1:0]  cfg_start_i,
  input  logic [CNT_W-1:0]   cfg_count_i,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic [UPPER_W-1:0] upper_addr_o
);
  logic sclk_s, csb_s, sdi_s;
  logic sclk_d, csb_d;
  logic sclk_rise, sclk_fall, csb_fall;
  logic byte_done, load;
  logic [BYTE_W-1:0] rx_byte, load_byte;

  dfb_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s));
  dfb_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync_csb (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(csb_i), .q_o(csb_s));
  dfb_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_sync_sdi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sdi_i), .q_o(sdi_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b1;
      csb_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csb_d  <= csb_s;
    end
  end

  assign sclk_rise = sclk_s && !sclk_d;
  assign sclk_fall = !sclk_s && sclk_d;
  assign csb_fall  = !csb_s && csb_d;

  dfb_shifter u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csb_i       (csb_s),
    .csb_fall_i  (csb_fall),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .sdi_i       (sdi_s),
    .load_i      (load),
    .load_byte_i (load_byte),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte),
    .sdo_o       (sdo_o)
  );

  dfb_ctrl #(.ADDR_W(ADDR_W), .UPPER_W(UPPER_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csb_i       (csb_s),
    .csb_fall_i  (csb_fall),
    .sclk_lvl_i  (sclk_s),
    .byte_done_i (byte_done),
    .rx_byte_i   (rx_byte),
    .cfg_start_i (cfg_start_i),
    .cfg_count_i (cfg_count_i),
    .rd_data_i   (rd_data_i),
    .rd_addr_o   (rd_addr_o),
    .load_o      (load),
    .load_byte_o (load_byte),
    .upper_o     (upper_addr_o)
  );
endmodule

// File: tb/dfb_spi_seq_tb.sv
module dfb_spi_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b1;
  logic       csb = 1'b1;
  logic       sdi = 1'b0;
  logic       sdo;
  logic [6:0] cfg_start = '0;
  logic [2:0] cfg_count = '0;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic [2:0] upper;

  int checks = 0;
  int fails  = 0;

  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] reg_val(input logic [6:0] a);
    return 8'(a * 29 + 91);
  endfunction

  assign rd_data = reg_val(rd_addr);

  dfb_spi_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csb_i(csb), .sdi_i(sdi),
    .sdo_o(sdo), .cfg_start_i(cfg_start), .cfg_count_i(cfg_count),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .upper_addr_o(upper)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic r);
    sclk = 1'b0;
    sdi  = b;
    wait_clk(HALF);
    r    = sdo;
    sclk = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, input bit chk, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    if (chk) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    for (int i = 7; i >= 0; i--) spi_bit(tx[i], got[i]);
    if (chk) act_q.push_back(got);
  endtask

  task automatic frame_start(input logic sclk_level);
    sclk = sclk_level;
    wait_clk(3);
    csb = 1'b0;
    wait_clk(2 * HALF);
  endtask

  task automatic frame_end();
    wait_clk(HALF);
    csb = 1'b1;
    wait_clk(2);
    sclk = 1'b1;
    wait_clk(3 * HALF);
  endtask

  // monitor: compares produced bytes against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_val(t, a, e);
      end
    end
  end

  initial begin
    wait_clk(100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic dummy;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    check_val("R1 sdo reset", sdo, 0);
    check_val("R1 upper reset", upper, 0);

    // R1/R2: status in normal mode
    frame_start(1'b1);
    xfer(8'hD5, 1, 8'h00, "R1 instr phase sdo");
    xfer(8'h00, 1, 8'h00, "R2 status off");
    frame_end();

    // R10: upper write and normal read
    frame_start(1'b1);
    xfer(8'h10, 0, 8'h00, "");
    xfer(8'h05, 0, 8'h00, "");
    xfer(8'h83, 0, 8'h00, "");
    xfer(8'h00, 1, reg_val(7'h53), "R10 normal read");
    frame_end();
    check_val("R10 upper set", upper, 5);

    // R2: enable
    frame_start(1'b1);
    xfer(8'hD1, 0, 8'h00, "");
    frame_end();

    // R3/R7: burst of 3 then status in same frame
    cfg_start = 7'h20; cfg_count = 3'd3;
    frame_start(1'b1);
    for (int i = 0; i < 3; i++) xfer(8'hFF, 1, reg_val(7'(7'h20 + i)), "R3 burst byte");
    xfer(8'hD5, 1, 8'h00, "R7 sdo after burst");
    xfer(8'h00, 1, 8'h02, "R2 status on");
    frame_end();
    check_val("R6 upper after burst", upper, 5);

    // R4/R5: count 0 means eight, wrap past top
    cfg_start = 7'h7C; cfg_count = 3'd0;
    frame_start(1'b1);
    for (int i = 0; i < 8; i++) xfer(8'h00, 1, reg_val(7'(7'h7C + i)), "R4 R5 wrap burst");
    xfer(8'h00, 1, 8'h00, "R4 no ninth byte");
    frame_end();
    check_val("R6 upper after long burst", upper, 5);

    // R8: abort mid-burst, then restart
    cfg_start = 7'h40; cfg_count = 3'd5;
    frame_start(1'b1);
    xfer(8'h00, 1, reg_val(7'h40), "R8 pre-abort");
    xfer(8'h00, 1, reg_val(7'h41), "R8 pre-abort");
    for (int i = 0; i < 4; i++) spi_bit(1'b0, dummy);
    frame_end();
    frame_start(1'b1);
    for (int i = 0; i < 5; i++) xfer(8'h00, 1, reg_val(7'(7'h40 + i)), "R8 restart");
    frame_end();

    // R9: SCLK low at CSB fall skips burst
    frame_start(1'b0);
    xfer(8'hD5, 0, 8'h00, "");
    xfer(8'h00, 1, 8'h02, "R9 no burst status");
    frame_end();

    // R6/R7: normal read and disable after burst in same frame
    cfg_start = 7'h10; cfg_count = 3'd1;
    frame_start(1'b1);
    xfer(8'h00, 1, reg_val(7'h10), "R3 single burst");
    xfer(8'h81, 0, 8'h00, "");
    xfer(8'h00, 1, reg_val(7'h51), "R6 read uses held upper");
    xfer(8'hD0, 0, 8'h00, "");
    frame_end();
    frame_start(1'b1);
    xfer(8'hD5, 1, 8'h00, "R2 R7 no burst after disable");
    xfer(8'h00, 1, 8'h00, "R2 status off again");
    frame_end();
    check_val("R6 upper final", upper, 5);

    wait_clk(10);
    check_val("scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule